// File: doc/BRIEF.md
# Interlocked Return-to-Zero Clock-Domain Transfer Link

This block moves single data words from a responder running on one clock to an initiator running on a second, unrelated clock. The two sides talk only through one request line and one acknowledge line, which are fully interlocked. The initiator raises request. The responder captures a word from its local source and places it on a shared parallel bus. Only after that does it raise acknowledge. The initiator then latches the bus and lowers request. The responder clears the bus and lowers acknowledge. Only then may a new request begin.

Each control line is resynchronized in the receiving domain through a chain of flip-flops. The data bus is not resynchronized. It is held steady by the responder for the whole time acknowledge is high, so the initiator can sample it directly once its synchronized copy of acknowledge is high. Only one transfer is ever in flight.

Top module: `hs4_xfer_top`

## Requirements
- R1: While either reset is low, the request output `m_req_o`, the acknowledge output `s_ack_o`, `m_busy` and `m_done` are all 0.
- R2: A high `m_start` sampled by the initiator while `m_busy` is 0 starts exactly one transfer, and `m_busy` is 1 after that edge. A high `m_start` sampled while `m_busy` is 1 is ignored and starts no extra transfer.
- R3: The responder captures `s_word` and pulses `s_fetch` for one responder cycle, then raises acknowledge on a later edge. The word on the bus is therefore stable before acknowledge rises.
- R4: Once acknowledge is high, the responder keeps it high and keeps the bus unchanged until its synchronized copy of request is low. Acknowledge never falls while request is still high.
- R5: After the responder sees request low, it clears the bus to all zeros and lowers acknowledge on the same edge. The initiator returns to idle (`m_busy` = 0) only once acknowledge is low.
- R6: The initiator raises request only when its synchronized copy of acknowledge is low, so request never rises while acknowledge is high.
- R7: Each control line crosses into the other domain through a synchronizer of SYNC_STAGES flip-flops (default 2). The data bus crosses without synchronization and is sampled only while the synchronized acknowledge is high.
- R8: Each transfer ends with `m_done` high for exactly one initiator cycle. `m_data` then equals the word the responder fetched for that transfer. Words arrive in fetch order with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m_clk | input | 1 | Initiator clock |
| m_rst_n | input | 1 | Initiator asynchronous active-low reset |
| s_clk | input | 1 | Responder clock |
| s_rst_n | input | 1 | Responder asynchronous active-low reset |
| m_start | input | 1 | Start request from initiator-side logic |
| m_busy | output | 1 | Initiator transfer in progress |
| m_done | output | 1 | One-cycle pulse: `m_data` holds a new word |
| m_data | output | DW | Last word received |
| m_req_o | output | 1 | Request line as driven by the initiator |
| s_word | input | DW | Word source on the responder side |
| s_fetch | output | 1 | One-cycle pulse: `s_word` was captured on the previous edge |
| s_ack_o | output | 1 | Acknowledge line as driven by the responder |

## Verification
Two pairs of events can fall on the same cycle. On the initiator side, a new start can coincide with the completion of the previous transfer. The bench holds `m_start` high for a long burst, so every start is presented either while busy or in the first idle cycle after acknowledge has fallen. It also drops single start pulses onto cycles where `m_done` or `m_busy` is high. The number of completed transfers must equal the number of starts that landed on an idle cycle, and every delivered word must match the queue of fetched words in order. On the responder side, a fresh `s_word` is driven in the same cycle the fetch pulse is seen. Because the bus was captured on the earlier edge, the word delivered must be the old value and not the new one.

// File: rtl/hs4_pkg.sv
package hs4_pkg;
  typedef enum logic [1:0] {
    M_IDLE,
    M_REQ,
    M_WAIT_ACK_LOW
  } mst_state_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SERVE,
    S_ACK,
    S_WAIT_REQ_LOW
  } slv_state_t;
endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

  initial begin
    assert_stages_min_R7: assert (STAGES >= 2)
      else $error("synchronizer needs at least two flops");
  end
endmodule

// File: rtl/hs4_master.sv
module hs4_master
  import hs4_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ack_s,
  input  logic [DW-1:0] bus,
  output logic          req,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] data
);
  mst_state_t state_q, state_d;
  logic          req_q;
  logic          done_q;
  logic [DW-1:0] data_q;
  logic          cap_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      M_IDLE:         if (start) state_d = M_REQ;
      M_REQ:          if (ack_s) state_d = M_WAIT_ACK_LOW;
      M_WAIT_ACK_LOW: if (!ack_s) state_d = M_IDLE;
      default:        state_d = M_IDLE;
    endcase
  end

  assign cap_en = (state_q == M_REQ) && ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= (state_d == M_REQ);
      done_q  <= cap_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (cap_en) data_q <= bus;
  end

  assign req  = req_q;
  assign busy = (state_q != M_IDLE);
  assign done = done_q;
  assign data = data_q;

  assert_req_rise_ack_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(!ack_s));
  assert_req_fall_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_s));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_idle_ack_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(!ack_s));
endmodule

// File: rtl/hs4_slave.sv
module hs4_slave
  import hs4_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_s,
  input  logic [DW-1:0] word,
  output logic          fetch,
  output logic          ack,
  output logic [DW-1:0] bus
);
  slv_state_t state_q, state_d;
  logic          ack_q;
  logic [DW-1:0] bus_q;
  logic          load_en;
  logic          clr_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:         if (req_s) state_d = S_SERVE;
      S_SERVE:        state_d = S_ACK;
      S_ACK:          state_d = S_WAIT_REQ_LOW;
      S_WAIT_REQ_LOW: if (!req_s) state_d = S_IDLE;
      default:        state_d = S_IDLE;
    endcase
  end

  assign load_en = (state_q == S_IDLE) && req_s;
  assign clr_en  = (state_q == S_WAIT_REQ_LOW) && !req_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_d == S_ACK) || (state_d == S_WAIT_REQ_LOW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_q <= '0;
    else if (load_en) bus_q <= word;
    else if (clr_en)  bus_q <= '0;
  end

  assign fetch = (state_q == S_SERVE);
  assign ack   = ack_q;
  assign bus   = bus_q;

  assert_data_before_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $stable(bus_q));
  assert_hold_while_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && $past(ack_q)) |-> $stable(bus_q));
  assert_ack_fall_req_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> $past(!req_s));
  assert_release_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> (bus_q == '0));
endmodule

// File: rtl/hs4_xfer_top.sv
module hs4_xfer_top #(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          m_clk,
  input  logic          m_rst_n,
  input  logic          s_clk,
  input  logic          s_rst_n,
  input  logic          m_start,
  output logic          m_busy,
  output logic          m_done,
  output logic [DW-1:0] m_data,
  output logic          m_req_o,
  input  logic [DW-1:0] s_word,
  output logic          s_fetch,
  output logic          s_ack_o
);
  logic          req_line;
  logic          ack_line;
  logic          req_in_s;
  logic          ack_in_m;
  logic [DW-1:0] data_bus;

  hs4_master #(.DW(DW)) u_mst (
    .clk   (m_clk),
    .rst_n (m_rst_n),
    .start (m_start),
    .ack_s (ack_in_m),
    .bus   (data_bus),
    .req   (req_line),
    .busy  (m_busy),
    .done  (m_done),
    .data  (m_data)
  );

  hs4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (s_clk),
    .rst_n (s_rst_n),
    .d     (req_line),
    .q     (req_in_s)
  );

  hs4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (m_clk),
    .rst_n (m_rst_n),
    .d     (ack_line),
    .q     (ack_in_m)
  );

  hs4_slave #(.DW(DW)) u_slv (
    .clk   (s_clk),
    .rst_n (s_rst_n),
    .req_s (req_in_s),
    .word  (s_word),
    .fetch (s_fetch),
    .ack   (ack_line),
    .bus   (data_bus)
  );

  assign m_req_o = req_line;
  assign s_ack_o = ack_line;
endmodule

// File: tb/tb_hs4_xfer_top.sv
`timescale 1ns/1ps
module tb_hs4_xfer_top;
  localparam int DW = 16;

  logic          m_clk = 1'b0;
  logic          s_clk = 1'b0;
  logic          m_rst_n, s_rst_n;
  logic          m_start;
  logic          m_busy, m_done, m_req_o, s_fetch, s_ack_o;
  logic [DW-1:0] m_data;
  logic [DW-1:0] s_word;

  int checks = 0;
  int errors = 0;
  int accepted = 0;
  int delivered = 0;
  logic [DW-1:0] fetched_q[$];
  bit   running = 1'b1;

  always #2    m_clk = ~m_clk;
  always #3.65 s_clk = ~s_clk;

  hs4_xfer_top #(.DW(DW), .SYNC_STAGES(2)) dut (
    .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk), .s_rst_n(s_rst_n),
    .m_start(m_start), .m_busy(m_busy), .m_done(m_done), .m_data(m_data),
    .m_req_o(m_req_o), .s_word(s_word), .s_fetch(s_fetch), .s_ack_o(s_ack_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Responder-side model: record fetched words, present a new one at once.
  logic prev_fetch = 1'b0;
  logic prev_ack_s = 1'b0;
  always @(negedge s_clk) begin
    if (s_rst_n && running) begin
      if (s_ack_o && !prev_ack_s) chk(prev_fetch == 1'b1, "R3 fetch before ack", prev_fetch, 1);
      if (!s_ack_o && prev_ack_s) chk(m_req_o == 1'b0, "R4 ack held while req high", m_req_o, 0);
      if (s_fetch) begin
        fetched_q.push_back(s_word);
        s_word = DW'($urandom);
      end
    end
    prev_fetch = s_fetch;
    prev_ack_s = s_ack_o;
  end

  // Initiator-side reference model, evaluated every initiator cycle.
  logic prev_req = 1'b0;
  logic prev_busy = 1'b0;
  logic expect_busy = 1'b0;
  logic prev_done = 1'b0;
  always @(negedge m_clk) begin
    if (m_rst_n && running) begin
      if (expect_busy) chk(m_busy == 1'b1, "R2 busy after accepted start", m_busy, 1);
      if (m_req_o && !prev_req) chk(s_ack_o == 1'b0, "R6 req rises with ack low", s_ack_o, 0);
      if (!m_busy && prev_busy) chk(s_ack_o == 1'b0, "R5 idle only after ack low", s_ack_o, 0);
      if (prev_done) chk(m_done == 1'b0, "R8 done is one cycle", m_done, 0);
      if (m_done) begin
        delivered++;
        if (fetched_q.size() == 0) chk(1'b0, "R8 word without fetch", m_data, 0);
        else begin
          logic [DW-1:0] exp_w;
          exp_w = fetched_q.pop_front();
          chk(m_data == exp_w, "R7 R8 delivered word", m_data, exp_w);
        end
      end
      expect_busy = m_start && !m_busy;
      if (expect_busy) accepted++;
    end
    prev_req  = m_req_o;
    prev_busy = m_busy;
    prev_done = m_done;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge m_clk);
    running = 1'b0;
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    m_rst_n = 1'b0;
    s_rst_n = 1'b0;
    m_start = 1'b0;
    s_word  = 16'hA5C3;
    repeat (5) @(posedge s_clk);
    #1;
    chk(m_req_o == 0, "R1 reset req", m_req_o, 0);
    chk(s_ack_o == 0, "R1 reset ack", s_ack_o, 0);
    chk(m_busy == 0,  "R1 reset busy", m_busy, 0);
    chk(m_done == 0,  "R1 reset done", m_done, 0);
    @(negedge m_clk) m_rst_n = 1'b1;
    @(negedge s_clk) s_rst_n = 1'b1;

    // Phase 1: isolated single starts.
    for (int i = 0; i < 6; i++) begin
      @(negedge m_clk) m_start = 1'b1;
      @(negedge m_clk) m_start = 1'b0;
      while (m_busy) @(negedge m_clk);
      repeat (3) @(negedge m_clk);
    end

    // Phase 2: start held high, back-to-back transfers.
    @(negedge m_clk) m_start = 1'b1;
    repeat (800) @(negedge m_clk);
    m_start = 1'b0;

    // Phase 3: random start pulses, many landing while busy or on done.
    for (int i = 0; i < 1500; i++) begin
      @(negedge m_clk);
      m_start = ($urandom_range(0, 3) == 0) || m_done;
    end
    @(negedge m_clk) m_start = 1'b0;

    repeat (60) @(negedge m_clk);
    running = 1'b0;
    chk(delivered == accepted, "R2 ignored starts add no transfer", delivered, accepted);
    chk(fetched_q.size() == 0, "R8 no word left undelivered", fetched_q.size(), 0);
    chk(m_req_o == 0 && s_ack_o == 0, "R5 lines back to zero", {m_req_o, s_ack_o}, 0);
    chk(accepted > 20, "R2 enough transfers exercised", accepted, 21);
    summary();
  end
endmodule